// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block holds five programmable alarm bytes (month, date, hour, minute, second) and compares them against the running calendar time. The clock block supplies that time in BCD together with a one-cycle 1 Hz tick. The tick is raised in the cycle in which the time fields already carry their new values. The comparison is taken only on that tick, so each matching second raises the alarm flag once. A flag read clears it again.

Each alarm byte carries a "don't care" bit that removes its field from the comparison. With these bits the alarm can repeat every second, minute, hour, day or month. An enable bit in the month byte decides whether a raised flag also pulls the active-low interrupt output down. The flag itself is set either way.

While the system runs from backup power, the alarm bytes are write-protected. Matching, flag setting and the interrupt keep working.

Top module: `calendar_alarm_unit`

## Requirements
- R1: After reset all five alarm bytes are zero, `alarm_flag_o` is 0 and `irq_n_o` is 1. With zeroed bytes, a tick whose month is not 00 sets nothing.
- R2: A write with `wr_en_i` high stores `wr_data_i` at these addresses: 2h second, 3h minute, 4h hour, 5h date, 6h month. A write to any other address changes no alarm byte.
- R3: When `tick_i` is high and every unmasked field equals its alarm byte, `alarm_flag_o` is 1 from the following cycle on.
- R4: Without `tick_i` the flag is never set, even when the time fields match.
- R5: The mask bit is bit 7 in the second, minute, hour and date bytes, and bit 6 in the month byte. A set mask bit removes that field from the comparison. With all masks set, every tick matches.
- R6: Only the field bits take part in the comparison: bits 6:0 for second and minute, bits 5:0 for hour and date, bits 4:0 for month. Other alarm-byte bits do not affect the match, and neither do the unused upper bits of the time inputs.
- R7: A `flag_rd_i` pulse clears the flag in the following cycle. If a tick match occurs in the same cycle as the read, the flag stays set.
- R8: `irq_n_o` is 0 exactly when the flag is set and the enable bit (bit 7 of the month byte) is 1.
- R9: While `on_backup_i` is 1, writes leave every alarm byte unchanged, and tick matches still set the flag and drive the interrupt.
- R10: With the enable bit at 0, a match still sets the flag while `irq_n_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 1 Hz pulse; the time fields are valid in that cycle |
| mon_i | input | 8 | Current month, BCD |
| date_i | input | 8 | Current day of month, BCD |
| hour_i | input | 8 | Current hour, BCD |
| min_i | input | 8 | Current minute, BCD |
| sec_i | input | 8 | Current second, BCD |
| on_backup_i | input | 1 | System on backup power; alarm bytes write-protected |
| wr_en_i | input | 1 | Write strobe for the alarm bytes |
| wr_addr_i | input | 4 | Register address of the write |
| wr_data_i | input | 8 | Write data |
| flag_rd_i | input | 1 | Read strobe of the flag byte; clears the alarm flag |
| alarm_flag_o | output | 1 | Alarm flag |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is a tick match in the very cycle of a flag read. The bench reads the flag while it is set and starts a matching tick in that same cycle. The set must win over the clear.

The second hard case is a write attempted under backup power. The bench blocks such a write and then presents a time that would match only if the write had landed. A missing flag at the port proves the write was ignored.

A behavioural model in the bench tracks both outcomes on every cycle.

// File: rtl/calalm_pkg.sv
package calalm_pkg;
  localparam int NFIELD = 5;
  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_DATE = 3'd3,
    FLD_MON  = 3'd4
  } field_e;

  // bits of a field that take part in the comparison
  function automatic byte_t keep_bits(input int idx);
    if (idx == int'(FLD_MON)) return 8'h1f;
    if (idx >= int'(FLD_HOUR)) return 8'h3f;
    return 8'h7f;
  endfunction

  // position of the don't-care bit within an alarm byte
  function automatic int mask_pos(input int idx);
    return (idx == int'(FLD_MON)) ? 6 : 7;
  endfunction

  function automatic logic field_hit(input byte_t alarm, input byte_t now, input int idx);
    byte_t keep;
    keep = keep_bits(idx);
    return alarm[mask_pos(idx)] || ((alarm & keep) == (now & keep));
  endfunction
endpackage

// File: rtl/alarm_bytes.sv
module alarm_bytes
  import calalm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BASE   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  byte_t                        wr_data,
  input  logic                         lock,
  output logic [NFIELD-1:0][BYTE_W-1:0] al_q
);
  for (genvar g = 0; g < NFIELD; g++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + g);
    logic sel;
    assign sel = wr_en && !lock && (wr_addr == MY_ADDR);
    always_ff @(posedge clk) begin
      if (!rst_n)   al_q[g] <= '0;
      else if (sel) al_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import calalm_pkg::*;
(
  input  logic [NFIELD-1:0][BYTE_W-1:0] al_q,
  input  logic [NFIELD-1:0][BYTE_W-1:0] now,
  output logic [NFIELD-1:0]             hit_vec,
  output logic                          match
);
  for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
    assign hit_vec[g] = field_hit(al_q[g], now[g], g);
  end
  assign match = &hit_vec;
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match,
  input  logic rd,
  input  logic en,
  output logic flag_q,
  output logic irq_n
);
  logic fire;
  assign fire = tick && match;

  always_ff @(posedge clk) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (fire) flag_q <= 1'b1;
    else if (rd)   flag_q <= 1'b0;
  end

  assign irq_n = !(flag_q && en);
endmodule

// File: rtl/calendar_alarm_unit.sv
module calendar_alarm_unit
  import calalm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BASE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [7:0]        mon_i,
  input  logic [7:0]        date_i,
  input  logic [7:0]        hour_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        sec_i,
  input  logic              on_backup_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              flag_rd_i,
  output logic              alarm_flag_o,
  output logic              irq_n_o
);
  logic [NFIELD-1:0][BYTE_W-1:0] al_q;
  logic [NFIELD-1:0][BYTE_W-1:0] now_w;
  logic [NFIELD-1:0]             hit_w;
  logic                          match_w;
  logic                          alarm_en_w;

  assign now_w[FLD_SEC]  = sec_i;
  assign now_w[FLD_MIN]  = min_i;
  assign now_w[FLD_HOUR] = hour_i;
  assign now_w[FLD_DATE] = date_i;
  assign now_w[FLD_MON]  = mon_i;
  assign alarm_en_w      = al_q[FLD_MON][7];

  alarm_bytes #(.ADDR_W(ADDR_W), .BASE(BASE)) u_bytes (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .lock(on_backup_i), .al_q(al_q)
  );

  alarm_compare u_cmp (
    .al_q(al_q), .now(now_w), .hit_vec(hit_w), .match(match_w)
  );

  alarm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .match(match_w), .rd(flag_rd_i),
    .en(alarm_en_w), .flag_q(alarm_flag_o), .irq_n(irq_n_o)
  );
endmodule

// File: rtl/calalm_chk.sv
module calalm_chk
  import calalm_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick_i,
  input logic                          match_w,
  input logic                          flag_rd_i,
  input logic                          alarm_flag_o,
  input logic                          irq_n_o,
  input logic                          alarm_en_w,
  input logic                          on_backup_i,
  input logic                          wr_en_i,
  input logic [NFIELD-1:0][BYTE_W-1:0] al_q
);
  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && match_w) |=> alarm_flag_o);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_i && !(tick_i && match_w)) |=> !alarm_flag_o);

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag_o) |-> $past(tick_i && match_w));

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (alarm_flag_o && alarm_en_w));

  // R10
  irq_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en_w |-> irq_n_o);

  // R9
  backup_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_backup_i && wr_en_i) |=> $stable(al_q));
endmodule

bind calendar_alarm_unit calalm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .match_w(match_w),
  .flag_rd_i(flag_rd_i), .alarm_flag_o(alarm_flag_o), .irq_n_o(irq_n_o),
  .alarm_en_w(alarm_en_w), .on_backup_i(on_backup_i), .wr_en_i(wr_en_i),
  .al_q(al_q)
);

// File: tb/tb_calendar_alarm_unit.sv
module tb_calendar_alarm_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] mon_i = 8'h01, date_i = 8'h01, hour_i = 8'h00, min_i = 8'h00, sec_i = 8'h00;
  logic       on_backup_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       flag_rd_i = 1'b0;
  logic       alarm_flag_o, irq_n_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  calendar_alarm_unit dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mon_i(mon_i), .date_i(date_i),
    .hour_i(hour_i), .min_i(min_i), .sec_i(sec_i), .on_backup_i(on_backup_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .flag_rd_i(flag_rd_i), .alarm_flag_o(alarm_flag_o), .irq_n_o(irq_n_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: index 0 second .. 4 month
  int m_al[5];
  bit m_flag;
  bit m_hit;

  function automatic bit model_match();
    int cur[5];
    cur[0] = sec_i; cur[1] = min_i; cur[2] = hour_i; cur[3] = date_i; cur[4] = mon_i;
    for (int i = 0; i < 5; i++) begin
      int width;
      bit dc;
      width = (i == 4) ? 5 : ((i >= 2) ? 6 : 7);
      dc = (i == 4) ? m_al[i][6] : m_al[i][7];
      if (!dc && ((m_al[i] % (1 << width)) != (cur[i] % (1 << width)))) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_al[i] = 0;
      m_flag = 0;
    end else begin
      m_hit = tick_i && model_match();
      if (m_hit) m_flag = 1;
      else if (flag_rd_i) m_flag = 0;
      if (wr_en_i && !on_backup_i && wr_addr_i >= 2 && wr_addr_i <= 6)
        m_al[wr_addr_i - 2] = wr_data_i;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(alarm_flag_o == m_flag, "R3", alarm_flag_o, m_flag);
      check(irq_n_o == !(m_flag && m_al[4][7]), "R8", irq_n_o, !(m_flag && m_al[4][7]));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic set_time(input logic [7:0] mo, da, ho, mi, se);
    mon_i = mo; date_i = da; hour_i = ho; min_i = mi; sec_i = se;
  endtask

  task automatic tick(input logic [7:0] mo, da, ho, mi, se, input bit rd = 0);
    set_time(mo, da, ho, mi, se);
    tick_i = 1; flag_rd_i = rd;
    @(negedge clk);
    tick_i = 0; flag_rd_i = 0;
  endtask

  task automatic rd();
    flag_rd_i = 1;
    @(negedge clk);
    flag_rd_i = 0;
  endtask

  task automatic expect_out(input bit f, input bit irqn, input string req);
    check(alarm_flag_o == f, req, alarm_flag_o, f);
    check(irq_n_o == irqn, req, irq_n_o, irqn);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, zero alarm bytes do not match a real date
    expect_out(0, 1, "R1");
    tick(8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    expect_out(0, 1, "R1");

    // R2 program 12/31 23:59:58 with enable
    wr(4'h6, 8'h92); wr(4'h5, 8'h31); wr(4'h4, 8'h23); wr(4'h3, 8'h59); wr(4'h2, 8'h58);
    tick(8'h12, 8'h31, 8'h23, 8'h59, 8'h57);
    expect_out(0, 1, "R3");
    tick(8'h12, 8'h31, 8'h23, 8'h59, 8'h58);
    expect_out(1, 0, "R3");
    // R7 read clears
    rd();
    expect_out(0, 1, "R7");

    // R2 writes outside 2h..6h ignored
    wr(4'h0, 8'hFF); wr(4'h1, 8'hFF); wr(4'h7, 8'hFF); wr(4'hF, 8'hFF);
    tick(8'h12, 8'h31, 8'h23, 8'h59, 8'h00);
    expect_out(0, 1, "R2");

    // R4 matching time without tick
    set_time(8'h12, 8'h31, 8'h23, 8'h59, 8'h58);
    repeat (4) @(negedge clk);
    expect_out(0, 1, "R4");

    // R5 second masked: repeats every second
    wr(4'h2, 8'h80);
    tick(8'h12, 8'h31, 8'h23, 8'h59, 8'h05);
    expect_out(1, 0, "R5");
    rd();
    tick(8'h12, 8'h31, 8'h23, 8'h59, 8'h06);
    expect_out(1, 0, "R5");
    rd();
    tick(8'h12, 8'h31, 8'h23, 8'h58, 8'h06);
    expect_out(0, 1, "R5");

    // R5 all fields masked, enable kept
    wr(4'h6, 8'hC0); wr(4'h5, 8'h80); wr(4'h4, 8'h80); wr(4'h3, 8'h80);
    tick(8'h03, 8'h07, 8'h11, 8'h22, 8'h33);
    expect_out(1, 0, "R5");
    rd();

    // R10 enable cleared: flag still sets, no interrupt
    wr(4'h6, 8'h40);
    tick(8'h05, 8'h09, 8'h01, 8'h02, 8'h03);
    expect_out(1, 1, "R10");
    rd();
    expect_out(0, 1, "R10");

    // R6 extra bits outside the field are ignored
    wr(4'h6, 8'hA3); wr(4'h5, 8'h55); wr(4'h4, 8'h40 | 8'h07); wr(4'h3, 8'h30); wr(4'h2, 8'h45);
    tick(8'h03, 8'h15, 8'h07, 8'h30, 8'h45);
    expect_out(1, 0, "R6");
    // R7 read with simultaneous match keeps the flag
    tick(8'h03, 8'h15, 8'h07, 8'h30, 8'h45, 1);
    expect_out(1, 0, "R7");
    rd();
    expect_out(0, 1, "R7");
    // R6 a differing field bit does prevent the match
    tick(8'h03, 8'h15, 8'h07, 8'h30, 8'h44);
    expect_out(0, 1, "R6");

    // R9 backup: writes blocked, alarm still works
    on_backup_i = 1;
    wr(4'h2, 8'h80);
    tick(8'h03, 8'h15, 8'h07, 8'h30, 8'h10);
    expect_out(0, 1, "R9");
    tick(8'h03, 8'h15, 8'h07, 8'h30, 8'h45);
    expect_out(1, 0, "R9");
    rd();
    on_backup_i = 0;
    @(negedge clk);
    expect_out(0, 1, "R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule